// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a watchdog that software arms once and then has to feed with a fixed pair of key writes. A single 32-bit control word sets everything: a 16-bit timeout, whether the watchdog runs, whether expiry raises a reset request or an interrupt, and whether each count step is stretched by a power-of-two prescaler (2^16 clocks by default). The first full-word write to the control word after power-on reset locks it. Later writes have no effect, so a watchdog left off stays off and a running one cannot be stopped.

Once enabled, a down-counter starts from the timeout and steps toward zero. Writing the two service keys in order to the halfword service register reloads the counter and restarts the prescaler. Any other value breaks the sequence. When the count is used up, the block either pulses a reset request for one clock or sets an interrupt flag. The interrupt flag stays set until the next valid service. The current count can be read at any time.

The register port is a single request channel with valid/ready. `req_ready` is held high, so the block never applies back-pressure and every request is taken in the cycle it is offered. A read answers with `rsp_valid` and data exactly one cycle after it is accepted. The response has no ready input, so the requester must capture the data in that cycle. Registers are big-endian: byte offset 0 of a word is carried on bits 31:24 and strobed by `req_be[3]`.

Top module: `kwdt_top`

## Requirements
- R1: After reset `wdt_rst_req`, `wdt_irq` and `rsp_valid` are low, and the control word (byte address 0x4) and count register (byte address 0x8) both read 0.
- R2: A write to byte address 0x4 with `req_be` = 4'hF, while unlocked, stores timeout = bits 31:16, enable = bit 2, reset-action = bit 1 and prescale = bit 0. The word then reads back as that value with bits 15:3 zero. A write with any other strobe pattern is ignored and does not lock.
- R3: After the first accepted control write, every later control write is ignored, whether it tries to enable, disable or change a field.
- R4: An enabling control write loads the counter with the timeout in that same clock edge. With prescale = 0 the count drops by one on every following clock. The count reads at byte address 0x8 in bits 15:0, with bits 31:16 zero.
- R5: With prescale = 1, the count drops by one once every 2^PRESC_LOG2 clocks, measured from the load.
- R6: Writing 0x556C and then 0xAA39 to byte address 0xE (data bits 15:0, `req_be[1:0]` = 2'b11) services the watchdog. On the edge that accepts the second key, the counter reloads with the timeout and the prescaler restarts.
- R7: Only writes to the service register move the key checker. A wrong value returns it to idle. 0x556C written while a first key is already pending counts as a fresh first key.
- R8: In reset mode (bit 1 = 1), when a count step leaves the count at 0, `wdt_rst_req` goes high for exactly one clock. The count then holds at 0 until a service.
- R9: In interrupt mode (bit 1 = 0), expiry sets `wdt_irq`. It stays high until the edge that accepts a valid service. `wdt_rst_req` is never raised in this mode.
- R10: `req_ready` is always high. Each accepted read gives `rsp_valid` exactly one cycle later with the register value seen at acceptance. Reserved addresses read 0, and writes to them do nothing.
- R11: A watchdog whose control word was locked with enable = 0 never asserts either expiry output, and services leave its count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| req_valid | input | 1 | Register request offered |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the access |
| req_be | input | 4 | Byte strobes, bit 3 = byte offset 0 (bits 31:24) |
| req_wdata | input | 32 | Write data, big-endian lanes |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | 32 | Read data |
| wdt_rst_req | output | 1 | One-clock reset request on expiry |
| wdt_irq | output | 1 | Sticky expiry interrupt |

## Verification
The bench builds the block with ADDR_W = 4 and PRESC_LOG2 = 4, so each prescaled step takes 16 clocks instead of 65536. That puts prescaled expiry, the prescaler restart on service, and the tick boundary within a few hundred cycles. Because the control word locks once per reset, the bench re-runs reset to cover each mode: reset action, interrupt action, prescaled, and locked-off. A behavioural model tracks the key checker, the counter and the expiry outputs on every clock.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

  // Timeout field width is fixed by the control word format.
  localparam int unsigned TMO_W = 16;

  // Byte addresses in the register window.
  localparam int unsigned ADR_CTRL = 4;
  localparam int unsigned ADR_CNT  = 8;
  localparam int unsigned ADR_SVC  = 14;

  // Control word bit positions (software decodes these).
  localparam int unsigned BIT_EN  = 2;
  localparam int unsigned BIT_ACT = 1;
  localparam int unsigned BIT_PRE = 0;

  // Service keys, in the order they must arrive.
  localparam logic [15:0] KEY_FIRST  = 16'h556C;
  localparam logic [15:0] KEY_SECOND = 16'hAA39;

  typedef enum logic {
    KS_IDLE  = 1'b0,
    KS_ARMED = 1'b1
  } key_state_e;

  typedef struct packed {
    logic [TMO_W-1:0] timeout;
    logic             enable;
    logic             act_reset;
    logic             prescale;
  } ctrl_s;

endpackage

// File: rtl/kwdt_regif.sv
module kwdt_regif
  import kwdt_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_be,
  input  logic [31:0]       req_wdata,
  input  ctrl_s             ctrl_q,
  input  logic [TMO_W-1:0]  cnt_q,
  output logic              ctrl_wr,
  output ctrl_s             ctrl_wfield,
  output logic              svc_wr,
  output logic [15:0]       svc_data,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADR_CTRL);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(ADR_CNT);
  localparam logic [ADDR_W-1:0] A_SVC  = ADDR_W'(ADR_SVC);
  localparam int unsigned       PAD_W  = 32 - TMO_W;

  logic        wr_acc;
  logic        rd_acc;
  logic [31:0] rd_word;

  assign wr_acc = req_valid && req_write;
  assign rd_acc = req_valid && !req_write;

  // Control takes only full-word writes; service takes the low halfword lanes.
  assign ctrl_wr = wr_acc && (req_addr == A_CTRL) && (req_be == 4'hF);
  assign svc_wr  = wr_acc && (req_addr == A_SVC) && (req_be[1:0] == 2'b11);
  assign svc_data = req_wdata[15:0];

  assign ctrl_wfield.timeout   = req_wdata[31:32-TMO_W];
  assign ctrl_wfield.enable    = req_wdata[BIT_EN];
  assign ctrl_wfield.act_reset = req_wdata[BIT_ACT];
  assign ctrl_wfield.prescale  = req_wdata[BIT_PRE];

  always_comb begin
    rd_word = '0;
    if (req_addr == A_CTRL) begin
      rd_word[31:32-TMO_W] = ctrl_q.timeout;
      rd_word[BIT_EN]      = ctrl_q.enable;
      rd_word[BIT_ACT]     = ctrl_q.act_reset;
      rd_word[BIT_PRE]     = ctrl_q.prescale;
    end else if (req_addr == A_CNT) begin
      rd_word = {{PAD_W{1'b0}}, cnt_q};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_acc;
      rsp_rdata <= rd_acc ? rd_word : '0;
    end
  end

endmodule

// File: rtl/kwdt_keyseq.sv
module kwdt_keyseq
  import kwdt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        svc_wr,
  input  logic [15:0] svc_data,
  output logic        svc_ok
);

  key_state_e state_q;
  key_state_e state_d;

  always_comb begin
    svc_ok  = 1'b0;
    state_d = state_q;
    if (svc_wr) begin
      if ((state_q == KS_ARMED) && (svc_data == KEY_SECOND)) begin
        svc_ok  = 1'b1;
        state_d = KS_IDLE;
      end else if (svc_data == KEY_FIRST) begin
        state_d = KS_ARMED;
      end else begin
        state_d = KS_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= KS_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/kwdt_ctrl_lock.sv
module kwdt_ctrl_lock
  import kwdt_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ctrl_wr,
  input  ctrl_s ctrl_wfield,
  output ctrl_s ctrl_q,
  output logic  locked,
  output logic  start
);

  logic accept;

  assign accept = ctrl_wr && !locked;
  assign start  = accept && ctrl_wfield.enable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      locked <= 1'b0;
    end else if (accept) begin
      ctrl_q <= ctrl_wfield;
      locked <= 1'b1;
    end
  end

endmodule

// File: rtl/kwdt_countdown.sv
module kwdt_countdown
  import kwdt_pkg::*;
#(
  parameter int PRESC_LOG2 = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [TMO_W-1:0] start_tmo,
  input  logic             reload,
  input  ctrl_s            ctrl_q,
  output logic [TMO_W-1:0] cnt_q,
  output logic             rst_req,
  output logic             irq
);

  logic fired;
  logic running;
  logic pre_wrap;
  logic tick;

  assign running = ctrl_q.enable && !fired;

  generate
    if (PRESC_LOG2 > 0) begin : g_pre
      logic [PRESC_LOG2-1:0] pc_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                pc_q <= '0;
        else if (start || reload)  pc_q <= '0;
        else if (running)          pc_q <= pc_q + 1'b1;
      end
      assign pre_wrap = &pc_q;
    end else begin : g_nopre
      assign pre_wrap = 1'b1;
    end
  endgenerate

  assign tick = !ctrl_q.prescale || pre_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      fired   <= 1'b0;
      rst_req <= 1'b0;
      irq     <= 1'b0;
    end else begin
      rst_req <= 1'b0;
      if (start) begin
        cnt_q <= start_tmo;
        fired <= 1'b0;
      end else if (reload) begin
        cnt_q <= ctrl_q.timeout;
        fired <= 1'b0;
        irq   <= 1'b0;
      end else if (running && tick) begin
        if (cnt_q <= TMO_W'(1)) begin
          cnt_q <= '0;
          fired <= 1'b1;
          if (ctrl_q.act_reset) rst_req <= 1'b1;
          else                  irq     <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int PRESC_LOG2 = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_be,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              wdt_rst_req,
  output logic              wdt_irq
);

  ctrl_s            ctrl_q;
  ctrl_s            ctrl_wfield;
  logic             ctrl_wr;
  logic             svc_wr;
  logic [15:0]      svc_data;
  logic             svc_ok;
  logic             locked;
  logic             start;
  logic             reload;
  logic [TMO_W-1:0] cnt_q;

  assign req_ready = 1'b1;
  assign reload    = svc_ok && ctrl_q.enable;

  kwdt_regif #(.ADDR_W(ADDR_W)) u_regif (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_be(req_be), .req_wdata(req_wdata),
    .ctrl_q(ctrl_q), .cnt_q(cnt_q),
    .ctrl_wr(ctrl_wr), .ctrl_wfield(ctrl_wfield),
    .svc_wr(svc_wr), .svc_data(svc_data),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  kwdt_keyseq u_keyseq (
    .clk(clk), .rst_n(rst_n),
    .svc_wr(svc_wr), .svc_data(svc_data), .svc_ok(svc_ok)
  );

  kwdt_ctrl_lock u_lock (
    .clk(clk), .rst_n(rst_n),
    .ctrl_wr(ctrl_wr), .ctrl_wfield(ctrl_wfield),
    .ctrl_q(ctrl_q), .locked(locked), .start(start)
  );

  kwdt_countdown #(.PRESC_LOG2(PRESC_LOG2)) u_count (
    .clk(clk), .rst_n(rst_n),
    .start(start), .start_tmo(ctrl_wfield.timeout),
    .reload(reload), .ctrl_q(ctrl_q),
    .cnt_q(cnt_q), .rst_req(wdt_rst_req), .irq(wdt_irq)
  );

endmodule

// File: rtl/kwdt_checker.sv
module kwdt_checker
  import kwdt_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_write,
  input logic             rsp_valid,
  input logic             wdt_rst_req,
  input logic             wdt_irq,
  input ctrl_s            ctrl_q,
  input logic             locked,
  input logic [TMO_W-1:0] cnt_q,
  input logic             start,
  input logic             reload
);

  // R3: locked control word never changes.
  assert_lock_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> (locked && $stable(ctrl_q)));

  // R4: without a load the count never goes up.
  assert_cnt_no_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !reload) |=> (cnt_q <= $past(cnt_q)));

  // R8: reset request is a single-clock pulse.
  assert_rst_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_req |=> !wdt_rst_req);

  // R9: interrupt only in interrupt mode, cleared by a service.
  assert_irq_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_irq |-> !ctrl_q.act_reset);
  assert_irq_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> !wdt_irq);

  // R10: one response per accepted read, one cycle later.
  assert_rsp_after_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);
  assert_rsp_only_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);

  // R11: a disabled watchdog stays silent.
  assert_quiet_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.enable |-> (!wdt_rst_req && !wdt_irq));

endmodule

bind kwdt_top kwdt_checker i_chk (
  .clk(clk), .rst_n(rst_n),
  .req_valid(req_valid), .req_write(req_write), .rsp_valid(rsp_valid),
  .wdt_rst_req(wdt_rst_req), .wdt_irq(wdt_irq),
  .ctrl_q(ctrl_q), .locked(locked), .cnt_q(cnt_q),
  .start(start), .reload(reload)
);

// File: tb/test_kwdt_top.sv
module test_kwdt_top;

  localparam int CLK_PERIOD = 10;
  localparam int PL2        = 4;
  localparam int PDIV       = 1 << PL2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        wdt_rst_req;
  logic        wdt_irq;

  kwdt_top #(.ADDR_W(4), .PRESC_LOG2(PL2)) i_kwdt_top (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .wdt_rst_req(wdt_rst_req), .wdt_irq(wdt_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit live = 1'b0;
  bit done = 1'b0;

  // Behavioural reference state
  bit        m_locked, m_armed, m_fired, m_rst, m_irq, m_rv;
  bit [31:0] m_ctrl, m_rd;
  int        m_cnt, m_pc;
  bit        b_cw, b_sw, b_good, b_start, b_reload, b_tick;

  function automatic void chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_locked = 0; m_armed = 0; m_fired = 0; m_rst = 0; m_irq = 0; m_rv = 0;
      m_ctrl = 0; m_rd = 0; m_cnt = 0; m_pc = 0;
    end else begin
      m_rv = req_valid && !req_write;
      m_rd = 0;
      if (m_rv) begin
        if (req_addr == 4'h4)      m_rd = m_ctrl;
        else if (req_addr == 4'h8) m_rd = {16'h0, m_cnt[15:0]};
      end
      b_cw = req_valid && req_write && req_addr == 4'h4 && req_be == 4'hF;
      b_sw = req_valid && req_write && req_addr == 4'hE && req_be[1:0] == 2'b11;
      b_good = 0;
      if (b_sw) begin
        if (m_armed && req_wdata[15:0] == 16'hAA39) begin b_good = 1; m_armed = 0; end
        else m_armed = (req_wdata[15:0] == 16'h556C);
      end
      b_start  = b_cw && !m_locked && req_wdata[2];
      b_reload = b_good && m_ctrl[2];
      m_rst = 0;
      if (b_start) begin
        m_cnt = int'(req_wdata[31:16]); m_pc = 0; m_fired = 0;
      end else if (b_reload) begin
        m_cnt = int'(m_ctrl[31:16]); m_pc = 0; m_fired = 0; m_irq = 0;
      end else if (m_ctrl[2] && !m_fired) begin
        b_tick = !m_ctrl[0] || (m_pc == PDIV - 1);
        m_pc = (m_pc + 1) % PDIV;
        if (b_tick) begin
          if (m_cnt <= 1) begin
            m_cnt = 0; m_fired = 1;
            if (m_ctrl[1]) m_rst = 1; else m_irq = 1;
          end else m_cnt = m_cnt - 1;
        end
      end
      if (b_cw && !m_locked) begin m_ctrl = req_wdata & 32'hFFFF0007; m_locked = 1; end
    end
  end

  // Per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (live && !done) begin
      chk(req_ready === 1'b1, "R10 ready", {31'h0, req_ready}, 32'h1);
      chk(wdt_rst_req === m_rst, "R8 rst_req", {31'h0, wdt_rst_req}, {31'h0, m_rst});
      chk(wdt_irq === m_irq, "R9 irq", {31'h0, wdt_irq}, {31'h0, m_irq});
      chk(rsp_valid === m_rv, "R10 rsp_valid", {31'h0, rsp_valid}, {31'h0, m_rv});
      if (m_rv) chk(rsp_rdata === m_rd, "R10 rsp_rdata", rsp_rdata, m_rd);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000 && !done) begin
      done = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic do_reset();
    live = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    live = 1'b1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_be = be; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_be = 4'hF;
    @(negedge clk);
    d = rsp_rdata;
    req_valid = 1'b0;
  endtask

  task automatic svc(input logic [15:0] k);
    wr(4'hE, 4'b0011, {16'h0, k});
  endtask

  logic [31:0] d;

  initial begin
    do_reset();
    // R1: reset state
    chk(wdt_rst_req == 0 && wdt_irq == 0 && rsp_valid == 0, "R1 outputs",
        {29'h0, wdt_rst_req, wdt_irq, rsp_valid}, 32'h0);
    rd(4'h4, d); chk(d == 32'h0, "R1 ctrl", d, 32'h0);
    rd(4'h8, d); chk(d == 32'h0, "R1 count", d, 32'h0);

    // Reset-action session, timeout 5, no prescale
    wr(4'h4, 4'hF, 32'h0005_0006);
    rd(4'h8, d); chk(d == 32'd5, "R4 load", d, 32'd5);
    rd(4'h8, d); chk(d == 32'd4, "R4 step", d, 32'd4);
    rd(4'h4, d); chk(d == 32'h0005_0006, "R2 readback", d, 32'h0005_0006);
    wr(4'h4, 4'hF, 32'h0000_0000);
    rd(4'h4, d); chk(d == 32'h0005_0006, "R3 locked", d, 32'h0005_0006);
    chk(wdt_rst_req == 1'b1, "R8 pulse", {31'h0, wdt_rst_req}, 32'h1);
    @(negedge clk);
    chk(wdt_rst_req == 1'b0, "R8 one cycle", {31'h0, wdt_rst_req}, 32'h0);
    rd(4'h8, d); chk(d == 32'd0, "R8 hold zero", d, 32'd0);
    svc(16'h556C); svc(16'hAA39);
    rd(4'h8, d); chk(d == 32'd5, "R6 reload", d, 32'd5);
    repeat (10) @(negedge clk);

    // Interrupt session, timeout 20
    do_reset();
    wr(4'h4, 4'hF, 32'h0014_0004);
    svc(16'h556C); svc(16'h1234); svc(16'hAA39);
    rd(4'h8, d); chk(d == 32'd17, "R7 broken sequence", d, 32'd17);
    svc(16'h556C); svc(16'h556C); svc(16'hAA39);
    rd(4'h8, d); chk(d == 32'd20, "R7 re-armed first key", d, 32'd20);
    repeat (30) @(negedge clk);
    chk(wdt_irq == 1'b1, "R9 irq set", {31'h0, wdt_irq}, 32'h1);
    repeat (20) @(negedge clk);
    chk(wdt_irq == 1'b1, "R9 irq sticky", {31'h0, wdt_irq}, 32'h1);
    svc(16'h556C); svc(16'hAA39);
    chk(wdt_irq == 1'b0, "R9 irq cleared", {31'h0, wdt_irq}, 32'h0);
    rd(4'h8, d); chk(d == 32'd20, "R6 reload irq mode", d, 32'd20);

    // Prescaled session, timeout 2
    do_reset();
    wr(4'h4, 4'hF, 32'h0002_0007);
    rd(4'h8, d); chk(d == 32'd2, "R5 load", d, 32'd2);
    repeat (9) @(negedge clk);
    rd(4'h8, d); chk(d == 32'd2, "R5 held within step", d, 32'd2);
    repeat (14) @(negedge clk);
    rd(4'h8, d); chk(d == 32'd1, "R5 one step", d, 32'd1);
    repeat (10) @(negedge clk);
    rd(4'h8, d); chk(d == 32'd0, "R5 expired", d, 32'd0);

    // Locked-off session
    do_reset();
    wr(4'h4, 4'h3, 32'h0005_0006);
    rd(4'h4, d); chk(d == 32'h0, "R2 partial write ignored", d, 32'h0);
    wr(4'h4, 4'hF, 32'h0005_0000);
    rd(4'h4, d); chk(d == 32'h0005_0000, "R2 disabled store", d, 32'h0005_0000);
    wr(4'h4, 4'hF, 32'h0005_0006);
    rd(4'h4, d); chk(d == 32'h0005_0000, "R3 no late enable", d, 32'h0005_0000);
    wr(4'h0, 4'hF, 32'hFFFF_FFFF);
    rd(4'h0, d); chk(d == 32'h0, "R10 reserved", d, 32'h0);
    repeat (20) @(negedge clk);
    rd(4'h8, d); chk(d == 32'h0, "R11 count idle", d, 32'h0);
    chk(wdt_rst_req == 0 && wdt_irq == 0, "R11 silent",
        {30'h0, wdt_rst_req, wdt_irq}, 32'h0);
    svc(16'h556C); svc(16'hAA39);
    rd(4'h8, d); chk(d == 32'h0, "R11 service no effect", d, 32'h0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule